// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable single-clock SRAM with a fully pipelined command path. It accepts one command on every enabled clock edge. A command is a read, a write, a deselect or a burst continue. Read data and write data both trail their address by the same two enabled edges, so reads and writes can be mixed freely on back-to-back cycles and the shared data bus carries a word on every cycle with no turnaround gap.

The data bus is modelled as three signals: an input word, an output word and a drive qualifier. The drive qualifier is turned off during the data phase of writes and deselects, and it is also gated combinationally by an asynchronous output enable. Each 9-bit lane of a write is masked by its own byte-enable. A four-beat burst reuses the page of the loaded address and steps the two low address bits in linear or interleaved order. A clock enable freezes every pipeline register in place.

A write commits to the array one enabled edge after its data is sampled. Until then it sits in a one-entry buffer, and reads that hit the buffer return its bytes merged with the stored word.

Top module: `pipe_sram`

## Requirements
- R1: A selected read whose command is captured on enabled edge k puts the addressed word on `rdata` with `rdata_oe` high after enabled edge k+2 (while `oe_n` is low).
- R2: A selected write whose command is captured on enabled edge k samples `wdata` on enabled edge k+2. Reads and writes may be issued on consecutive enabled edges in any mix with no idle cycle.
- R3: Lane i is bits [9i+8:9i] of the word. A write changes lane i only when `byte_en[i]` was 1 in the cycle the command was captured. Other lanes keep their previous contents.
- R4: A load is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Otherwise it is a deselect: it accesses nothing, `wdata` at its data edge is ignored, and `rdata_oe` is low after its data edge.
- R5: After the data edge of a write, `rdata_oe` is low.
- R6: While `oe_n` is 1, `rdata_oe` is 0 at once, whatever the internal state. When `oe_n` returns to 0, the internal drive state reappears.
- R7: On a clock edge with `clk_en`=0, no register changes. `rdata` and `rdata_oe` hold, pending commands do not advance, and that edge does not count toward the latencies of R1 and R2.
- R8: `burst_adv`=0 loads a new command. `burst_adv`=1 continues the last loaded burst. A continue keeps the upper address bits, and its n-th beat (n=1,2,3, then wrapping) uses low bits (start+n) mod 4 when `burst_ilv` was 0 at the load.
- R9: When `burst_ilv` was 1 at the load, the n-th continue beat uses low bits start XOR n.
- R10: A continue keeps the direction and the selection of the burst it extends. `wr_en`, `addr` and the chip selects are ignored on a continue, while `byte_en` is taken per beat.
- R11: A read that reaches its data edge while an earlier write to the same address is still uncommitted returns that write's enabled lanes merged with the older contents.
- R12: An active-low reset discards commands in flight and drives `rdata_oe` low. After reset a continue with no prior load is a deselect. The array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Clock enable, 0 freezes the pipeline |
| burst_adv | input | 1 | 1 = continue burst, 0 = load new command |
| addr | input | AW (6) | Word address of a load |
| wr_en | input | 1 | 1 = write, 0 = read, sampled on a load |
| byte_en | input | LANES (4) | Per-lane write enables |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | WORD_W (36) | Write data from the bus |
| rdata | output | WORD_W (36) | Registered read data |
| rdata_oe | output | 1 | Data bus drive qualifier |

## Verification
Every selected read is due on `rdata` and `rdata_oe` after the second enabled edge following its capture, and every write consumes `wdata` on that same second enabled edge. Deselects and writes must leave `rdata_oe` low after that edge. The bench keeps a two-entry history of the commands it captured and shifts it only on cycles with `clk_en` high. It drives the data-phase write word before the edge and samples outputs at the following falling edge, compared against a reference memory updated at each write's data edge. On stalled edges it checks that both outputs repeat the values seen one cycle earlier. The asynchronous output enable is checked within the same cycle, a moment after it toggles.

// File: rtl/psram_pkg.sv
package psram_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits for a burst beat: linear counts up and wraps,
  // interleaved flips start bits by the beat number.
  function automatic logic [BURST_W-1:0] burst_offset(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input logic               ilv
  );
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/psram_burst_gen.sv
module psram_burst_gen
  import psram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          adv,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_wr,
  input  logic          ld_sel,
  input  logic          ld_ilv,
  output op_e           cmd_op,
  output logic [AW-1:0] cmd_addr
);

  localparam int PW = AW - BURST_W;

  logic [PW-1:0]      page_q,  page_d;
  logic [BURST_W-1:0] start_q, start_d;
  logic [BURST_W-1:0] beat_q,  beat_d;
  logic               dir_q,   dir_d;
  logic               act_q,   act_d;
  logic               ilv_q,   ilv_d;
  op_e                op_q,    op_d;
  logic [AW-1:0]      addr_q,  addr_d;
  logic [BURST_W-1:0] beat_nx;

  assign beat_nx = beat_q + 1'b1;

  always_comb begin
    page_d  = page_q;
    start_d = start_q;
    beat_d  = beat_q;
    dir_d   = dir_q;
    act_d   = act_q;
    ilv_d   = ilv_q;
    if (adv) begin
      beat_d = beat_nx;
      addr_d = {page_q, burst_offset(start_q, beat_nx, ilv_q)};
      if (!act_q)     op_d = OP_IDLE;
      else if (dir_q) op_d = OP_WRITE;
      else            op_d = OP_READ;
    end else begin
      page_d  = ld_addr[AW-1:BURST_W];
      start_d = ld_addr[BURST_W-1:0];
      beat_d  = '0;
      dir_d   = ld_wr;
      act_d   = ld_sel;
      ilv_d   = ld_ilv;
      addr_d  = ld_addr;
      if (!ld_sel)    op_d = OP_IDLE;
      else if (ld_wr) op_d = OP_WRITE;
      else            op_d = OP_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      start_q <= '0;
      beat_q  <= '0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
      ilv_q   <= 1'b0;
      op_q    <= OP_IDLE;
      addr_q  <= '0;
    end else if (clk_en) begin
      page_q  <= page_d;
      start_q <= start_d;
      beat_q  <= beat_d;
      dir_q   <= dir_d;
      act_q   <= act_d;
      ilv_q   <= ilv_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
    end
  end

  assign cmd_op   = op_q;
  assign cmd_addr = addr_q;

endmodule

// File: rtl/psram_store.sv
module psram_store
  import psram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  op_e                     op,
  input  logic [$clog2(DEPTH)-1:0] acc_addr,
  input  logic [LANES-1:0]        acc_mask,
  input  logic [LANES*LANE_W-1:0] wr_word,
  output logic [LANES*LANE_W-1:0] rd_word
);

  localparam int AW     = $clog2(DEPTH);
  localparam int WORD_W = LANES * LANE_W;

  // One-entry late-write buffer: data sampled now, array written next edge.
  logic              pend_vld_q;
  logic [AW-1:0]     pend_addr_q;
  logic [LANES-1:0]  pend_mask_q;
  logic [WORD_W-1:0] pend_data_q;
  logic              pend_hit;
  logic              do_wr;

  assign do_wr    = (op == OP_WRITE);
  assign pend_hit = pend_vld_q && (pend_addr_q == acc_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_vld_q <= 1'b0;
    else if (clk_en) pend_vld_q <= do_wr;
  end

  always_ff @(posedge clk) begin
    if (clk_en) begin
      pend_addr_q <= acc_addr;
      pend_mask_q <= acc_mask;
      pend_data_q <= wr_word;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (clk_en && pend_vld_q && pend_mask_q[l])
        lane_mem[pend_addr_q] <= pend_data_q[l*LANE_W +: LANE_W];
    end

    assign rd_word[l*LANE_W +: LANE_W] =
      (pend_hit && pend_mask_q[l]) ? pend_data_q[l*LANE_W +: LANE_W]
                                   : lane_mem[acc_addr];
  end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import psram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clk_en,
  input  logic                           burst_adv,
  input  logic [$clog2(DEPTH)-1:0]       addr,
  input  logic                           wr_en,
  input  logic [LANES-1:0]               byte_en,
  input  logic                           sel_a_n,
  input  logic                           sel_b,
  input  logic                           sel_c_n,
  input  logic                           burst_ilv,
  input  logic                           oe_n,
  input  logic [LANES*LANE_W-1:0]        wdata,
  output logic [LANES*LANE_W-1:0]        rdata,
  output logic                           rdata_oe
);

  localparam int AW     = $clog2(DEPTH);
  localparam int WORD_W = LANES * LANE_W;

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Stage A: command capture and burst sequencing.
  logic          sel_ok;
  op_e           op_a;
  logic [AW-1:0] addr_a;
  logic [LANES-1:0] mask_a_q;

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  psram_burst_gen #(.AW(AW)) i_burst_gen (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clk_en   (clk_en),
    .adv      (burst_adv),
    .ld_addr  (addr),
    .ld_wr    (wr_en),
    .ld_sel   (sel_ok),
    .ld_ilv   (burst_ilv),
    .cmd_op   (op_a),
    .cmd_addr (addr_a)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mask_a_q <= '0;
    else if (clk_en)  mask_a_q <= byte_en;
  end

  // Stage B: one register stage so data trails address by two edges.
  op_e              op_b_q;
  logic [AW-1:0]    addr_b_q;
  logic [LANES-1:0] mask_b_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_b_q   <= OP_IDLE;
      addr_b_q <= '0;
      mask_b_q <= '0;
    end else if (clk_en) begin
      op_b_q   <= op_a;
      addr_b_q <= addr_a;
      mask_b_q <= mask_a_q;
    end
  end

  // Data stage: array access, write sampling and read forwarding.
  logic [WORD_W-1:0] rd_word;

  psram_store #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) i_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clk_en   (clk_en),
    .op       (op_b_q),
    .acc_addr (addr_b_q),
    .acc_mask (mask_b_q),
    .wr_word  (wdata),
    .rd_word  (rd_word)
  );

  // Output register and synchronous drive control.
  logic [WORD_W-1:0] rdat_q, rdat_d;
  logic              drv_q,  drv_d;

  always_comb begin
    drv_d  = (op_b_q == OP_READ);
    rdat_d = drv_d ? rd_word : rdat_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdat_q <= '0;
      drv_q  <= 1'b0;
    end else if (clk_en) begin
      rdat_q <= rdat_d;
      drv_q  <= drv_d;
    end
  end

  assign rdata    = rdat_q;
  assign rdata_oe = drv_q && !oe_n;

endmodule

// File: rtl/psram_chk.sv
module psram_chk #(
  parameter int AW = 6,
  parameter int W  = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          burst_adv,
  input logic          oe_n,
  input logic          rdata_oe,
  input logic [W-1:0]  rdata,
  input logic [1:0]    op_a,
  input logic [AW-1:0] addr_a,
  input logic [1:0]    op_b
);

  localparam logic [1:0] K_IDLE  = 2'd0;
  localparam logic [1:0] K_READ  = 2'd1;
  localparam logic [1:0] K_WRITE = 2'd2;

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && op_b == K_READ) |=> (rdata_oe || oe_n)); // R1

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && op_b == K_IDLE) |=> !rdata_oe); // R4

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && op_b == K_WRITE) |=> !rdata_oe); // R5

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(rdata)); // R7

  AST_BURST_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && burst_adv) |=> (addr_a[AW-1:2] == $past(addr_a[AW-1:2]))); // R8

  AST_BURST_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && burst_adv) |=> (op_a == $past(op_a))); // R10

endmodule

bind pipe_sram psram_chk #(.AW(AW), .W(WORD_W)) i_psram_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .clk_en    (clk_en),
  .burst_adv (burst_adv),
  .oe_n      (oe_n),
  .rdata_oe  (rdata_oe),
  .rdata     (rdata),
  .op_a      (op_a),
  .addr_a    (addr_a),
  .op_b      (op_b_q)
);

// File: tb/test_pipe_sram.sv
`timescale 1ns/1ps
module test_pipe_sram;

  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DEPTH  = 64;
  localparam int AW     = 6;
  localparam int W      = LANES * LANE_W;
  localparam logic [2:0] SEL_ON = 3'b010;

  logic clk, rst_n, clk_en, burst_adv, wr_en, sel_a_n, sel_b, sel_c_n;
  logic burst_ilv, oe_n, rdata_oe;
  logic [AW-1:0] addr;
  logic [LANES-1:0] byte_en;
  logic [W-1:0] wdata, rdata;

  pipe_sram #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) i_pipe_sram (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .burst_adv(burst_adv),
    .addr(addr), .wr_en(wr_en), .byte_en(byte_en), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .burst_ilv(burst_ilv), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic             vld;
    logic             wr;
    logic [AW-1:0]    a;
    logic [LANES-1:0] m;
  } op_t;

  int n_run, n_fail;
  logic [W-1:0] ref_mem [DEPTH];
  op_t h1, h2;
  bit b_sel, b_wr, b_ilv;
  logic [AW-1:0] b_base;
  logic [1:0] b_start, b_cnt;
  logic [W-1:0] last_rd;
  logic last_drv;

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_word();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[W-1:0];
  endfunction

  // One clock cycle: drive at the falling edge, check at the next one.
  task automatic cyc(input bit ce, input bit adv, input logic [AW-1:0] a,
                     input bit wr, input logic [LANES-1:0] m,
                     input logic [2:0] sp, input bit ilv, input string tag);
    op_t cur, d;
    logic [W-1:0] wd;
    cur = '0;
    d   = h2;
    wd  = rnd_word();
    clk_en = ce; burst_adv = adv; addr = a; wr_en = wr; byte_en = m;
    {sel_a_n, sel_b, sel_c_n} = sp; burst_ilv = ilv; wdata = wd;
    if (ce) begin
      if (!adv) begin
        b_sel = (sp == SEL_ON); b_base = a; b_start = a[1:0];
        b_cnt = 2'd0; b_wr = wr; b_ilv = ilv;
        cur.a = a;
      end else begin
        b_cnt = b_cnt + 2'd1;
        cur.a = {b_base[AW-1:2], b_ilv ? (b_start ^ b_cnt) : (b_start + b_cnt)};
      end
      cur.vld = b_sel; cur.wr = b_wr; cur.m = m;
    end
    @(posedge clk);
    @(negedge clk);
    if (ce) begin
      if (d.vld && d.wr) begin
        for (int l = 0; l < LANES; l++)
          if (d.m[l]) ref_mem[d.a][l*LANE_W +: LANE_W] = wd[l*LANE_W +: LANE_W];
        check(rdata_oe === 1'b0, {"R5 ", tag}, W'(rdata_oe), '0);
      end else if (d.vld) begin
        check(rdata_oe === 1'b1, {"R1 ", tag}, W'(rdata_oe), W'(1));
        check(rdata === ref_mem[d.a], {"R1_R11 ", tag}, rdata, ref_mem[d.a]);
      end else begin
        check(rdata_oe === 1'b0, {"R4 ", tag}, W'(rdata_oe), '0);
      end
      h2 = h1;
      h1 = cur;
    end else begin
      check(rdata === last_rd, {"R7 ", tag}, rdata, last_rd);
      check(rdata_oe === last_drv, {"R7 ", tag}, W'(rdata_oe), W'(last_drv));
    end
    last_rd  = rdata;
    last_drv = rdata_oe;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, '0, 0, '0, 3'b110, 0, tag);
  endtask

  task automatic do_reset();
    clk_en = 0; burst_adv = 0; oe_n = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    check(rdata_oe === 1'b0, "R12 reset", W'(rdata_oe), '0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    h1 = '0; h2 = '0; b_sel = 0; b_cnt = '0;
    last_rd = rdata; last_drv = rdata_oe;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    n_run = 0; n_fail = 0;
    void'($urandom(32'h5a17c3e1));
    h1 = '0; h2 = '0; b_sel = 0; b_wr = 0; b_ilv = 0; b_base = '0;
    b_start = '0; b_cnt = '0;
    wdata = '0; addr = '0; wr_en = 0; byte_en = '0;
    {sel_a_n, sel_b, sel_c_n} = 3'b110; burst_ilv = 0;
    @(negedge clk);
    do_reset();
    check(rdata === '0, "R12 rdata after reset", rdata, '0);

    // Fill every word with full-lane writes so the reference is defined.
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, AW'(i), 1, '1, SEL_ON, 0, "fill");
    idle(3, "flush");

    // R2: strict read/write alternation, every cycle.
    for (int i = 0; i < 12; i++)
      cyc(1, 0, AW'(i % 3), i[0], '1, SEL_ON, 0, "R2 alternate");
    idle(2, "R2 drain");

    // R3: partial lane writes then reads after commit.
    cyc(1, 0, 6'd20, 1, 4'b0101, SEL_ON, 0, "R3 mask");
    cyc(1, 0, 6'd21, 1, 4'b1000, SEL_ON, 0, "R3 mask");
    cyc(1, 0, 6'd22, 1, 4'b0000, SEL_ON, 0, "R3 none");
    idle(3, "R3 gap");
    cyc(1, 0, 6'd20, 0, '0, SEL_ON, 0, "R3 read");
    cyc(1, 0, 6'd21, 0, '0, SEL_ON, 0, "R3 read");
    cyc(1, 0, 6'd22, 0, '0, SEL_ON, 0, "R3 read");
    idle(2, "R3 drain");

    // R11: read immediately after partial write to same word.
    cyc(1, 0, 6'd30, 1, 4'b0110, SEL_ON, 0, "R11 wr");
    cyc(1, 0, 6'd30, 0, '0,      SEL_ON, 0, "R11 rd");
    cyc(1, 0, 6'd31, 1, 4'b1001, SEL_ON, 0, "R11 wr");
    cyc(1, 1, 6'd0,  0, '0,      SEL_ON, 0, "R11 cont");
    cyc(1, 0, 6'd31, 0, '0,      SEL_ON, 0, "R11 rd");
    idle(2, "R11 drain");

    // R4: deselected write leaves target untouched.
    cyc(1, 0, 6'd40, 1, '1, 3'b000, 0, "R4 desel");
    cyc(1, 0, 6'd40, 1, '1, 3'b011, 0, "R4 desel");
    cyc(1, 0, 6'd40, 1, '1, 3'b110, 0, "R4 desel");
    idle(2, "R4 gap");
    cyc(1, 0, 6'd40, 0, '0, SEL_ON, 0, "R4 readback");
    idle(2, "R4 drain");

    // R8: linear burst write from offset 2, then linear read from offset 3.
    cyc(1, 0, 6'd14, 1, '1, SEL_ON, 0, "R8 lin wr");
    for (int i = 0; i < 3; i++) cyc(1, 1, '0, 0, '1, 3'b111, 1, "R8 lin wr");
    cyc(1, 0, 6'd15, 0, '0, SEL_ON, 0, "R8 lin rd");
    for (int i = 0; i < 4; i++) cyc(1, 1, 6'd0, 1, '0, 3'b000, 1, "R8 R10 lin rd");
    idle(2, "R8 drain");

    // R9: interleaved burst write from offset 1, interleaved read from 2.
    cyc(1, 0, 6'd49, 1, '1, SEL_ON, 1, "R9 ilv wr");
    for (int i = 0; i < 3; i++) cyc(1, 1, '0, 0, '1, 3'b110, 0, "R9 ilv wr");
    cyc(1, 0, 6'd50, 0, '0, SEL_ON, 1, "R9 ilv rd");
    for (int i = 0; i < 5; i++) cyc(1, 1, 6'd7, 1, '1, 3'b100, 0, "R9 R10 ilv rd");
    idle(2, "R9 drain");

    // R7: stalls in the middle of a write/read mix.
    cyc(1, 0, 6'd5, 1, '1, SEL_ON, 0, "R7 wr");
    cyc(0, 0, 6'd6, 0, '1, SEL_ON, 0, "R7 stall");
    cyc(1, 0, 6'd5, 0, '0, SEL_ON, 0, "R7 rd");
    cyc(0, 1, 6'd9, 1, '1, SEL_ON, 1, "R7 stall");
    cyc(0, 0, 6'd9, 1, '1, SEL_ON, 1, "R7 stall");
    cyc(1, 0, 6'd5, 0, '0, SEL_ON, 0, "R7 rd");
    cyc(0, 0, 6'd1, 1, '1, SEL_ON, 0, "R7 stall");
    idle(3, "R7 drain");

    // R6: asynchronous output enable while a read is driving.
    cyc(1, 0, 6'd3, 0, '0, SEL_ON, 0, "R6 rd");
    idle(1, "R6 wait");
    cyc(1, 0, '0, 0, '0, 3'b110, 0, "R6 data");
    v = rdata;
    cyc(0, 0, '0, 0, '0, 3'b110, 0, "R6 hold");
    oe_n = 1; #1;
    check(rdata_oe === 1'b0, "R6 oe_n high", W'(rdata_oe), '0);
    oe_n = 0; #1;
    check(rdata_oe === 1'b1, "R6 oe_n low", W'(rdata_oe), W'(1));
    check(rdata === v, "R6 data kept", rdata, v);
    idle(2, "R6 drain");

    // Random mix.
    for (int i = 0; i < 1500; i++) begin
      bit ce, adv, wr, ilv;
      logic [AW-1:0] a;
      logic [2:0] sp;
      ce  = ($urandom() % 8) != 0;
      adv = ($urandom() % 3) == 0;
      wr  = $urandom() % 2;
      ilv = $urandom() % 2;
      a   = (($urandom() % 4) == 0) ? AW'($urandom()) : AW'($urandom() % 8);
      sp  = (($urandom() % 6) == 0) ? 3'($urandom() | 1) : SEL_ON;
      cyc(ce, adv, a, wr, LANES'($urandom()), sp, ilv, "random");
    end
    idle(3, "random drain");

    // R12: reset with reads in flight, then continue without a load.
    idle(4, "R12 pre");
    cyc(1, 0, 6'd8, 0, '0, SEL_ON, 0, "R12 rd");
    cyc(1, 0, 6'd9, 0, '0, SEL_ON, 0, "R12 rd");
    do_reset();
    cyc(1, 1, 6'd8, 0, '0, SEL_ON, 0, "R12 cont");
    cyc(1, 1, 6'd8, 0, '0, SEL_ON, 0, "R12 cont");
    cyc(1, 0, 6'd9, 0, '0, SEL_ON, 0, "R12 rd");
    idle(3, "R12 drain");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule